// File: doc/BRIEF.md
# SD Host Error Interrupt Status Register

This block holds the error half of the interrupt status of a secure-digital host controller. Error events from the data path, the descriptor-DMA engine and the automatic stop-command logic are latched into sticky status bits. Software reads the 16-bit register through a simple register port and clears bits by writing ones. Two masks are supplied from elsewhere in the controller. The status-enable mask decides which bits may latch. The signal-enable mask decides which latched bits drive the single interrupt line.

Two small detectors are part of the block. One flags a zero sampled at an end-bit position on the data line. It covers both the end of read data and the end of the CRC status token. The other compares a received 3-bit write CRC status token against the good pattern. The stop-command error bit is raised by a rising edge on any bit of an external error-status vector. The previous value of that vector is held inside the block.

Top module: `sdh_err_irq_reg`

## Requirements
- R1: While synchronous active-low reset is applied, and on the first cycle after it, reg_rdata is 0 and irq is 0.
- R2: Bits 15:10, bit 7 (current limit, not implemented) and bits 3:0 always read 0, whatever is written and whatever events arrive.
- R3: A write with reg_wr=1 clears each status bit whose reg_wdata bit is 1 and leaves bits written with 0 unchanged. Several bits may clear in one write.
- R4: A status bit can latch only when its stat_en bit is 1. sig_en has no effect on latching.
- R5: irq is a register equal to the OR over all bits of (status AND sig_en) as it stood one cycle earlier.
- R6: Bit 9 sets on adma_err, or on adma_fetch_invalid (a descriptor fetched with its valid flag at 0).
- R7: Bit 8 sets in the cycle after any bit of acmd_err_vec reads 1 where it read 0 in the previous cycle (the held value is 0 after reset). A vector held at 1 does not set it again.
- R8: Bit 6 sets when rd_endbit_stb or tok_endbit_stb is 1 while dat_bit is 0. A strobe with dat_bit at 1 does not set it.
- R9: Bit 5 sets on rd_crc_err, or when tok_valid is 1 and tok_status is not binary 010. A token of 010, or any token with tok_valid at 0, does not set it.
- R10: Bit 4 sets on data_timeout or on busy_timeout.
- R11: When a set event and a write-1 clear hit the same bit in the same cycle, the bit ends up set.
- R12: An event on cycle k is visible on reg_rdata after the clock edge that ends cycle k (one-cycle latency).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe (write-1-to-clear) |
| reg_wdata | input | 16 | Write data, ones clear bits |
| reg_rdata | output | 16 | Current status value |
| stat_en | input | 16 | Per-bit latch enable |
| sig_en | input | 16 | Per-bit interrupt enable |
| adma_err | input | 1 | Descriptor-DMA transfer error pulse |
| adma_fetch_invalid | input | 1 | Descriptor fetched with valid flag 0 in fetch state |
| acmd_err_vec | input | ACMD_W | Stop-command error-status vector |
| rd_crc_err | input | 1 | Read data CRC mismatch pulse |
| data_timeout | input | 1 | Data timeout pulse |
| busy_timeout | input | 1 | Busy timeout pulse for R1b/R5b responses |
| rd_endbit_stb | input | 1 | dat_bit holds the read data end bit this cycle |
| tok_endbit_stb | input | 1 | dat_bit holds the CRC status token end bit this cycle |
| dat_bit | input | 1 | Sampled data line value |
| tok_valid | input | 1 | tok_status holds a received write CRC status token |
| tok_status | input | 3 | Write CRC status token bits |
| irq | output | 1 | Error interrupt request |

## Verification
Status bits are due one edge after their event or clear (R12). The stop-command bit is due one edge after the first cycle in which the vector shows a new one. irq trails the status and sig_en by a further edge. The bench drives inputs on falling edges and reads outputs on falling edges. A reference model advances on each rising edge with exactly these latencies, so every comparison lands on the cycle where the result is due. The targeted checks read the outputs at the first falling edge after the edge that must have produced the result.

// File: rtl/sdh_err_pkg.sv
// Package: shared widths, bit positions and constants of the error
// interrupt status register. Assumes a 16-bit register layout.
package sdh_err_pkg;
    localparam int REG_W   = 16;
    localparam int TOK_W   = 3;
    localparam logic [TOK_W-1:0] TOK_GOOD = 3'b010;

    localparam int B_TOUT   = 4;
    localparam int B_CRC    = 5;
    localparam int B_ENDBIT = 6;
    localparam int B_ILIM   = 7;
    localparam int B_ACMD   = 8;
    localparam int B_ADMA   = 9;

    // Bits that hold state in this block; all others read 0.
    localparam logic [REG_W-1:0] IMPL_MASK =
        (REG_W'(1) << B_TOUT) | (REG_W'(1) << B_CRC) | (REG_W'(1) << B_ENDBIT) |
        (REG_W'(1) << B_ACMD) | (REG_W'(1) << B_ADMA);
endpackage

// File: rtl/sdh_endbit_det.sv
// Module: flags a zero on the data line at an end-bit position.
// Assumes the strobes mark the single cycle in which dat_bit holds
// the end bit of read data or of the CRC status token.
module sdh_endbit_det (
    input  logic rd_stb,
    input  logic tok_stb,
    input  logic dat_bit,
    output logic err
);
    // An end bit must be 1; a 0 under either strobe is an error.
    always_comb err = (rd_stb | tok_stb) & ~dat_bit;
endmodule

// File: rtl/sdh_tok_chk.sv
// Module: compares a received write CRC status token with the good
// pattern. Assumes tok is meaningful only while valid is 1.
module sdh_tok_chk
    import sdh_err_pkg::*;
(
    input  logic             valid,
    input  logic [TOK_W-1:0] tok,
    output logic             bad
);
    // Any pattern other than the good one is a CRC failure report.
    always_comb bad = valid & (tok != TOK_GOOD);
endmodule

// File: rtl/sdh_acmd_rise.sv
// Module: detects a 0-to-1 change on any bit of the stop-command
// error-status vector. Holds the previous value, cleared by reset.
module sdh_acmd_rise #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] vec,
    output logic         rise
);
    logic [W-1:0] prev_q;

    // Keep last cycle's vector for the edge compare.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= vec;
    end

    // Any bit now 1 that was 0 one cycle ago.
    always_comb rise = |(vec & ~prev_q);
endmodule

// File: rtl/sdh_sticky_bit.sv
// Module: one sticky status bit with write-1 clear. A set in the same
// cycle as a clear wins, so no event is lost.
module sdh_sticky_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    // Hold, clear on request, set dominant.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= set | (q & ~clr);
    end
endmodule

// File: rtl/sdh_err_irq_reg.sv
// Module: error interrupt status register of an SD host controller.
// Collects error events, latches them under stat_en, clears them by
// write-1, and drives a registered interrupt under sig_en.
// Assumes event inputs are single-cycle pulses, synchronous to clk.
module sdh_err_irq_reg
    import sdh_err_pkg::*;
#(
    parameter int ACMD_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [REG_W-1:0]  stat_en,
    input  logic [REG_W-1:0]  sig_en,
    input  logic              adma_err,
    input  logic              adma_fetch_invalid,
    input  logic [ACMD_W-1:0] acmd_err_vec,
    input  logic              rd_crc_err,
    input  logic              data_timeout,
    input  logic              busy_timeout,
    input  logic              rd_endbit_stb,
    input  logic              tok_endbit_stb,
    input  logic              dat_bit,
    input  logic              tok_valid,
    input  logic [TOK_W-1:0]  tok_status,
    output logic              irq
);
    logic             endbit_err;
    logic             tok_bad;
    logic             acmd_rise;
    logic [REG_W-1:0] ev;
    logic [REG_W-1:0] status_q;

    sdh_endbit_det u_endbit (
        .rd_stb  (rd_endbit_stb),
        .tok_stb (tok_endbit_stb),
        .dat_bit (dat_bit),
        .err     (endbit_err)
    );

    sdh_tok_chk u_tok (
        .valid (tok_valid),
        .tok   (tok_status),
        .bad   (tok_bad)
    );

    sdh_acmd_rise #(.W(ACMD_W)) u_acmd (
        .clk   (clk),
        .rst_n (rst_n),
        .vec   (acmd_err_vec),
        .rise  (acmd_rise)
    );

    // Map each error source onto its status bit position.
    always_comb begin
        ev           = '0;
        ev[B_TOUT]   = data_timeout | busy_timeout;
        ev[B_CRC]    = rd_crc_err | tok_bad;
        ev[B_ENDBIT] = endbit_err;
        ev[B_ACMD]   = acmd_rise;
        ev[B_ADMA]   = adma_err | adma_fetch_invalid;
    end

    for (genvar i = 0; i < REG_W; i++) begin : g_bit
        if (IMPL_MASK[i]) begin : g_impl
            sdh_sticky_bit u_bit (
                .clk   (clk),
                .rst_n (rst_n),
                .set   (ev[i] & stat_en[i]),
                .clr   (reg_wr & reg_wdata[i]),
                .q     (status_q[i])
            );
        end else begin : g_zero
            assign status_q[i] = 1'b0;
        end
    end

    assign reg_rdata = status_q;

    // Interrupt: registered OR of signalled status bits.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |(status_q & sig_en);
    end
endmodule

// File: rtl/sdh_err_irq_chk.sv
// Checker: temporal properties of the error interrupt status register,
// bound to every instance of sdh_err_irq_reg.
module sdh_err_irq_chk
    import sdh_err_pkg::*;
#(
    parameter int ACMD_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [REG_W-1:0]  reg_wdata,
    input logic [REG_W-1:0]  reg_rdata,
    input logic [REG_W-1:0]  stat_en,
    input logic [REG_W-1:0]  sig_en,
    input logic              adma_err,
    input logic              data_timeout,
    input logic              busy_timeout,
    input logic              rd_crc_err,
    input logic [ACMD_W-1:0] acmd_err_vec,
    input logic              irq
);
    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[15:10] == '0) && !reg_rdata[B_ILIM] && (reg_rdata[3:0] == '0));

    assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_wdata[B_TOUT] && !data_timeout && !busy_timeout)
        |=> !reg_rdata[B_TOUT]);

    assert_no_latch_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_rdata[B_CRC] && !stat_en[B_CRC]) |=> !reg_rdata[B_CRC]);

    assert_irq_lag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past(|(reg_rdata & sig_en))));

    assert_acmd_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_en[B_ACMD] && |(acmd_err_vec & ~$past(acmd_err_vec)))
        |=> reg_rdata[B_ACMD]);

    assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (adma_err && stat_en[B_ADMA] && reg_wr && reg_wdata[B_ADMA])
        |=> reg_rdata[B_ADMA]);
endmodule

bind sdh_err_irq_reg sdh_err_irq_chk #(.ACMD_W(ACMD_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .stat_en      (stat_en),
    .sig_en       (sig_en),
    .adma_err     (adma_err),
    .data_timeout (data_timeout),
    .busy_timeout (busy_timeout),
    .rd_crc_err   (rd_crc_err),
    .acmd_err_vec (acmd_err_vec),
    .irq          (irq)
);

// File: tb/sdh_err_irq_reg_tb.sv
`timescale 1ns/1ps
module sdh_err_irq_reg_tb_top;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [15:0]   reg_wdata = '0;
    logic [15:0]   reg_rdata;
    logic [15:0]   stat_en = '0;
    logic [15:0]   sig_en = '0;
    logic          adma_err = 1'b0, adma_fetch_invalid = 1'b0;
    logic [AW-1:0] acmd_err_vec = '0;
    logic          rd_crc_err = 1'b0, data_timeout = 1'b0, busy_timeout = 1'b0;
    logic          rd_endbit_stb = 1'b0, tok_endbit_stb = 1'b0, dat_bit = 1'b1;
    logic          tok_valid = 1'b0;
    logic [2:0]    tok_status = 3'b000;
    logic          irq;

    int    n_chk = 0, n_fail = 0, cyc = 0;
    string cur_req = "R1";
    logic  model_ok = 1'b0;
    logic [15:0]   m_stat = '0;
    logic          m_irq = 1'b0;
    logic [AW-1:0] m_prev = '0;

    always #2 clk = ~clk;   // 250 MHz

    sdh_err_irq_reg #(.ACMD_W(AW)) dut_i (.*);

    // Reference model: behavioural, advances on each rising edge.
    always @(posedge clk) begin
        logic [15:0] nxt, hit;
        model_ok <= 1'b1;
        if (!rst_n) begin
            m_stat <= '0; m_irq <= 1'b0; m_prev <= '0;
        end else begin
            hit = '0;
            if (data_timeout || busy_timeout) hit[4] = 1'b1;
            if (rd_crc_err || (tok_valid && tok_status != 3'b010)) hit[5] = 1'b1;
            if ((rd_endbit_stb || tok_endbit_stb) && dat_bit == 1'b0) hit[6] = 1'b1;
            for (int b = 0; b < AW; b++)
                if (acmd_err_vec[b] && !m_prev[b]) hit[8] = 1'b1;
            if (adma_err || adma_fetch_invalid) hit[9] = 1'b1;
            nxt = m_stat;
            if (reg_wr) nxt = nxt & ~reg_wdata;
            nxt = (nxt | (hit & stat_en)) & 16'h0370;
            m_irq  <= (m_stat & sig_en) != 0;
            m_stat <= nxt;
            m_prev <= acmd_err_vec;
        end
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the rising edge.
    always @(negedge clk) begin
        cyc++;
        if (model_ok) begin
            chk({cur_req, " status"}, reg_rdata, m_stat);
            chk({cur_req, " irq"}, {15'd0, irq}, {15'd0, m_irq});
        end
        if (cyc > 20000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected below 20000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // Clear all one-cycle pulses at the next falling edge.
    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            reg_wr = 0; reg_wdata = '0; adma_err = 0; adma_fetch_invalid = 0;
            rd_crc_err = 0; data_timeout = 0; busy_timeout = 0;
            rd_endbit_stb = 0; tok_endbit_stb = 0; dat_bit = 1; tok_valid = 0;
        end
    endtask

    task automatic wr(input logic [15:0] d);
        @(negedge clk); reg_wr = 1; reg_wdata = d;
        idle(1);
    endtask

    initial begin
        // R1: reset state
        cur_req = "R1";
        idle(3);
        chk("R1 rdata", reg_rdata, 16'h0000);
        chk("R1 irq", {15'd0, irq}, 16'h0000);
        @(negedge clk); rst_n = 1;
        idle(1);
        chk("R1 after release", reg_rdata, 16'h0000);
        stat_en = 16'hFFFF;

        // R6: descriptor-DMA error and invalid descriptor
        cur_req = "R6";
        @(negedge clk); adma_err = 1;
        idle(1);
        chk("R6 adma_err R12", reg_rdata, 16'h0200);
        wr(16'h0200);
        @(negedge clk); adma_fetch_invalid = 1;
        idle(1);
        chk("R6 fetch invalid", reg_rdata, 16'h0200);

        // R3: write 0 keeps, multi-bit clear
        cur_req = "R3";
        wr(16'h0000);
        chk("R3 zero write", reg_rdata, 16'h0200);
        @(negedge clk); data_timeout = 1; rd_crc_err = 1;
        idle(1);
        chk("R3 setup", reg_rdata, 16'h0230);
        wr(16'h0220);
        chk("R3 partial clear", reg_rdata, 16'h0010);
        wr(16'hFFFF);
        chk("R3 clear all", reg_rdata, 16'h0000);

        // R7: vector rising edge
        cur_req = "R7";
        @(negedge clk); acmd_err_vec = 5'b00100;
        idle(1);
        chk("R7 rise", reg_rdata, 16'h0100);
        wr(16'h0100);
        idle(2);
        chk("R7 held no reset", reg_rdata, 16'h0000);
        @(negedge clk); acmd_err_vec = 5'b10100;
        idle(1);
        chk("R7 second bit", reg_rdata, 16'h0100);
        @(negedge clk); acmd_err_vec = '0;
        wr(16'h0100);

        // R8: end bit detector
        cur_req = "R8";
        @(negedge clk); rd_endbit_stb = 1; dat_bit = 1;
        idle(1);
        chk("R8 good end bit", reg_rdata, 16'h0000);
        @(negedge clk); rd_endbit_stb = 1; dat_bit = 0;
        idle(1);
        chk("R8 read end bit 0", reg_rdata, 16'h0040);
        wr(16'h0040);
        @(negedge clk); tok_endbit_stb = 1; dat_bit = 0;
        idle(1);
        chk("R8 token end bit 0", reg_rdata, 16'h0040);
        wr(16'h0040);

        // R9: CRC token
        cur_req = "R9";
        @(negedge clk); tok_valid = 1; tok_status = 3'b010;
        idle(1);
        chk("R9 good token", reg_rdata, 16'h0000);
        @(negedge clk); tok_valid = 0; tok_status = 3'b101;
        idle(1);
        chk("R9 invalid strobe", reg_rdata, 16'h0000);
        @(negedge clk); tok_valid = 1; tok_status = 3'b101;
        idle(1);
        chk("R9 bad token", reg_rdata, 16'h0020);
        wr(16'h0020);
        @(negedge clk); rd_crc_err = 1;
        idle(1);
        chk("R9 read crc", reg_rdata, 16'h0020);
        wr(16'h0020);

        // R10: timeouts
        cur_req = "R10";
        @(negedge clk); busy_timeout = 1;
        idle(1);
        chk("R10 busy timeout", reg_rdata, 16'h0010);
        wr(16'h0010);

        // R4: status-enable gates latching; sig_en does not
        cur_req = "R4";
        stat_en = 16'hFFDF; sig_en = 16'h0000;
        @(negedge clk); rd_crc_err = 1; adma_err = 1;
        idle(1);
        chk("R4 masked bit", reg_rdata, 16'h0200);
        wr(16'h0200);
        stat_en = 16'hFFFF;

        // R5: interrupt one cycle after status
        cur_req = "R5";
        sig_en = 16'h0010;
        @(negedge clk); data_timeout = 1;
        idle(1);
        chk("R5 status first", {15'd0, irq}, 16'h0000);
        idle(1);
        chk("R5 irq next", {15'd0, irq}, 16'h0001);
        sig_en = 16'h0000;
        idle(1);
        chk("R5 irq follows sig_en", {15'd0, irq}, 16'h0000);
        wr(16'h0010);

        // R11: set beats clear in the same cycle
        cur_req = "R11";
        @(negedge clk); adma_err = 1; reg_wr = 1; reg_wdata = 16'h0200;
        idle(1);
        chk("R11 set wins", reg_rdata, 16'h0200);
        wr(16'h0200);

        // R2: reserved and unimplemented bits stay 0
        cur_req = "R2";
        @(negedge clk);
        adma_err = 1; rd_crc_err = 1; data_timeout = 1; dat_bit = 0;
        rd_endbit_stb = 1; acmd_err_vec = 5'b11111; reg_wr = 1; reg_wdata = 16'h0000;
        idle(1);
        chk("R2 reserved zero", reg_rdata & 16'hFC8F, 16'h0000);
        chk("R2 all sources", reg_rdata, 16'h0370);
        wr(16'hFFFF);
        idle(2);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule